// File: doc/BRIEF.md
# Dual-Channel High/Low-Count Pulse Generator

This block drives two independent pulse outputs, A and B, from a small bank of 32-bit registers written over a simple word-addressed bus. Each output's waveform comes from two 16-bit counts: how many ticks the output stays high, followed by how many ticks it stays low. The cycle then repeats. Each channel has its own 7-bit prescaler, and one tick of that channel equals the prescale field plus one clock cycles.

A single shared control word holds the following per-channel settings: the output enable, the clock enable, the prescale field, a clock-source select field, and a noise-shaping mode bit. The block only stores the clock-source select; it does not act on it. When the noise-shaping mode bit is set, the output is held low. Count changes written while a channel runs take effect only at the end of the current period, so a pulse is never cut short or stretched partway through.

Five more register words exist only as plain storage. All registers reset to zero.

Top module: `pwm2ch_top`

## Requirements
- R1: Eight 32-bit registers sit at word index 0 to 7, and the byte address is the word index times 4. Each register resets to zero and reads back the last value written to it, including the control word's clock-source fields (bits 5:4 for A, 7:6 for B).
- R2: Word 0 sets channel A and word 1 sets channel B. In each, the high count is bits 31:16 and the low count is bits 15:0.
- R3: Word 2 is the control word. When a channel starts, its output is high for high × (div+1) cycles and then low for low × (div+1) cycles, and this repeats. The output is high in the first cycle after the enabling write.
- R4: The control word holds the prescale field `div` in bits 14:8 for A and 22:16 for B. The channel ticks every div+1 cycles, up to a divide of 128 when the field is 127.
- R5: A channel runs only while both its output enable (bit 0 for A, bit 1 for B) and its clock enable (bit 15 for A, bit 23 for B) are set. Otherwise its output is low and its counters are cleared, so re-enabling it restarts it at the high phase.
- R6: A high count of 0 keeps the output low. A low count of 0 with a non-zero high count keeps it high.
- R7: Setting the noise-shaping bit (bit 2 for A, bit 3 for B) holds that output low, and the other channel is not affected.
- R8: A count write to a running channel takes effect from the next period boundary. A write that lands on the same edge as a boundary waits one more full period.
- R9: The two channels run independently, each with its own counts and prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | Write strobe for one cycle |
| busAddr | input | 5 | Byte address; bits 4:2 select the word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the word at busAddr, combinational |
| pwmOutA | output | 1 | Channel A pulse output |
| pwmOutB | output | 1 | Channel B pulse output |

## Verification
Two events can meet on one clock edge: a bus write to a running channel's count word, and that channel's end-of-period reload. The bench provokes this on purpose. It places the write one cycle before a computed boundary, so the write lands on the reload edge itself. It also runs a second case where the write lands mid-period. In both cases the whole output trace is compared with arithmetic expectations. In the same-edge case, the old counts must run for one more complete period. In the mid-period case, the new counts must begin at the very next boundary.

// File: rtl/pwm2ch_pkg.sv
package pwm2ch_pkg;
  parameter int NUM_CH   = 2;
  parameter int CNT_W    = 16;
  parameter int DIV_W    = 7;
  parameter int WORD_W   = 32;
  parameter int NUM_REGS = 8;
  localparam int REG_IDX_W = $clog2(NUM_REGS);
  // word placement of the per-channel count words and the shared control word
  localparam int DUTY_BASE = 0;
  localparam int CTRL_IDX  = 2;
  // control word layout
  localparam int OUT_EN_LSB  = 0;
  localparam int MUTE_LSB    = 2;
  localparam int DIV_LSB     = 8;
  localparam int LANE_STRIDE = 8;

  // strobes and settings handed from the register side to one lane
  typedef struct packed {
    logic             run;
    logic             mute;
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
  } chanCfg_t;
endpackage

// File: rtl/pwm2ch_regs.sv
module pwm2ch_regs
  import pwm2ch_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busWrite,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [WORD_W-1:0]             busWdata,
  output logic [WORD_W-1:0]             busRdata,
  output logic [WORD_W-1:0]             ctrlWord,
  output logic [NUM_CH-1:0][WORD_W-1:0] dutyWord,
  output chanCfg_t [NUM_CH-1:0]         chanCfg
);
  localparam int BYTE_LSB = $clog2(WORD_W / 8);

  logic [NUM_REGS-1:0][WORD_W-1:0] regFile;
  logic [REG_IDX_W-1:0]            wordIdx;

  assign wordIdx = busAddr[BYTE_LSB +: REG_IDX_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regFile <= '0;
    end else if (busWrite) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (wordIdx == REG_IDX_W'(r)) regFile[r] <= busWdata;
      end
    end
  end

  assign busRdata = regFile[wordIdx];
  assign ctrlWord = regFile[CTRL_IDX];

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
      localparam int LANE_LSB = DIV_LSB + c * LANE_STRIDE;
      assign dutyWord[c]     = regFile[DUTY_BASE + c];
      assign chanCfg[c].run  = ctrlWord[OUT_EN_LSB + c] & ctrlWord[LANE_LSB + DIV_W];
      assign chanCfg[c].mute = ctrlWord[MUTE_LSB + c];
      assign chanCfg[c].div  = ctrlWord[LANE_LSB +: DIV_W];
      assign chanCfg[c].hi   = dutyWord[c][WORD_W-1 -: CNT_W];
      assign chanCfg[c].lo   = dutyWord[c][CNT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/pwm2ch_lane.sv
module pwm2ch_lane
  import pwm2ch_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  chanCfg_t cfg,
  output logic     pwmOut
);
  logic [DIV_W-1:0] preCnt;
  logic [CNT_W:0]   pos;
  logic [CNT_W-1:0] shHi;
  logic [CNT_W-1:0] shLo;
  logic [CNT_W:0]   span;
  logic             tick;
  logic             lastPos;

  assign span    = {1'b0, shHi} + {1'b0, shLo};
  assign tick    = cfg.run && (preCnt == cfg.div);
  assign lastPos = (span == '0) || (pos == span - (CNT_W+1)'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      pos    <= '0;
      shHi   <= '0;
      shLo   <= '0;
    end else if (!cfg.run) begin
      // idle: clear the counters and keep the shadow tracking the live counts
      preCnt <= '0;
      pos    <= '0;
      shHi   <= cfg.hi;
      shLo   <= cfg.lo;
    end else begin
      preCnt <= tick ? '0 : preCnt + DIV_W'(1);
      if (tick) begin
        if (lastPos) begin
          pos  <= '0;
          shHi <= cfg.hi;
          shLo <= cfg.lo;
        end else begin
          pos <= pos + (CNT_W+1)'(1);
        end
      end
    end
  end

  assign pwmOut = cfg.run && !cfg.mute && (pos < {1'b0, shHi});
endmodule

// File: rtl/pwm2ch_datapath.sv
module pwm2ch_datapath
  import pwm2ch_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  chanCfg_t [NUM_CH-1:0] chanCfg,
  output logic [NUM_CH-1:0]     pwmOut
);
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      pwm2ch_lane u_lane (
        .clk    (clk),
        .rstN   (rstN),
        .cfg    (chanCfg[c]),
        .pwmOut (pwmOut[c])
      );
    end
  endgenerate
endmodule

// File: rtl/pwm2ch_top.sv
module pwm2ch_top
  import pwm2ch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrite,
  input  logic [4:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        pwmOutA,
  output logic        pwmOutB
);
  logic [WORD_W-1:0]             ctrlWord;
  logic [NUM_CH-1:0][WORD_W-1:0] dutyWord;
  logic [WORD_W-1:0]             dutyA;
  logic [WORD_W-1:0]             dutyB;
  chanCfg_t [NUM_CH-1:0]         chanCfg;
  logic [NUM_CH-1:0]             pwmOut;

  pwm2ch_regs #(.ADDR_W(5)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .ctrlWord (ctrlWord),
    .dutyWord (dutyWord),
    .chanCfg  (chanCfg)
  );

  pwm2ch_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .chanCfg (chanCfg),
    .pwmOut  (pwmOut)
  );

  assign dutyA   = dutyWord[0];
  assign dutyB   = dutyWord[1];
  assign pwmOutA = pwmOut[0];
  assign pwmOutB = pwmOut[1];
endmodule

// File: rtl/pwm2ch_checker.sv
module pwm2ch_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busWrite,
  input logic [4:0]  busAddr,
  input logic [31:0] busWdata,
  input logic        pwmOutA,
  input logic        pwmOutB,
  input logic [31:0] ctrlWord,
  input logic [31:0] dutyA,
  input logic [31:0] dutyB
);
  assert_ctrl_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr[4:2] == 3'd2) |=> ctrlWord == $past(busWdata));

  assert_idle_low_a_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrlWord[0] && ctrlWord[15]) |-> !pwmOutA);

  assert_idle_low_b_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrlWord[1] && ctrlWord[23]) |-> !pwmOutB);

  assert_mute_low_a_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWord[2] |-> !pwmOutA);

  assert_mute_low_b_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWord[3] |-> !pwmOutB);

  assert_start_high_a_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord[0] && ctrlWord[15] && !ctrlWord[2] && dutyA[31:16] != 16'd0 &&
     !$past(ctrlWord[0] && ctrlWord[15])) |-> pwmOutA);

  assert_start_high_b_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord[1] && ctrlWord[23] && !ctrlWord[3] && dutyB[31:16] != 16'd0 &&
     !$past(ctrlWord[1] && ctrlWord[23])) |-> pwmOutB);
endmodule

bind pwm2ch_top pwm2ch_checker u_chk (.*);

// File: tb/pwm2ch_top_tb.sv
module pwm2ch_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        pwmOutA;
  logic        pwmOutB;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pwm2ch_top u_dut (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pwmOutA(pwmOutA), .pwmOutB(pwmOutB)
  );

  function automatic int expOut(int t, int hi, int lo, int dv);
    if (hi == 0) return 0;
    if (lo == 0) return 1;
    return (((t / (dv + 1)) % (hi + lo)) < hi) ? 1 : 0;
  endfunction

  function automatic logic [31:0] mkCtl(bit enA, bit ckA, int dvA, bit msA,
                                        bit enB, bit ckB, int dvB, bit msB);
    logic [31:0] w;
    w = '0;
    w[0] = enA; w[1] = enB; w[2] = msA; w[3] = msB;
    w[14:8] = 7'(dvA); w[15] = ckA;
    w[22:16] = 7'(dvB); w[23] = ckB;
    return w;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h time=%0t", req, act, exp, $time);
    end
  endtask

  task automatic busWr(input int idx, input logic [31:0] d);
    busAddr = 5'(idx * 4); busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rdChk(input int idx, input logic [31:0] exp, input string req);
    busAddr = 5'(idx * 4);
    #1;
    chk(req, busRdata, exp);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // mid-run count update: old 3/2 div1, new 1/1, write issued at sample w
  task automatic updTest(input int w, input int boundary);
    busWr(0, {16'd3, 16'd2});
    busWr(2, mkCtl(1, 1, 1, 0, 0, 0, 0, 0));
    for (int t = 0; t < 46; t++) begin
      chk("R8", pwmOutA, (t < boundary) ? expOut(t, 3, 2, 1) : expOut(t - boundary, 1, 1, 1));
      if (t == w) busWr(0, {16'd1, 16'd1});
      else @(negedge clk);
    end
    busWr(2, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL all requirements: watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    // R1: reset values
    for (int i = 0; i < 8; i++) rdChk(i, 32'h0, "R1");
    chk("R5", pwmOutA, 0);
    chk("R5", pwmOutB, 0);
    // R1: readback of every word, including clock-source select bits
    for (int i = 0; i < 8; i++) busWr(i, 32'h13579BDF ^ (32'h11111111 * i) ^ 32'h000000F0);
    for (int i = 0; i < 8; i++) rdChk(i, 32'h13579BDF ^ (32'h11111111 * i) ^ 32'h000000F0, "R1");
    doReset();

    // R2 R3 R6 R9: sweep of counts and prescale on both channels at once
    for (int hi = 0; hi < 4; hi++)
      for (int lo = 0; lo < 4; lo++)
        for (int dv = 0; dv < 3; dv++) begin
          int dB;
          string reqA;
          dB = (dv + 1) % 3;
          reqA = (hi == 0 || lo == 0) ? "R6" : "R2/R3";
          busWr(0, {16'(hi), 16'(lo)});
          busWr(1, {16'(lo), 16'(hi)});
          busWr(2, mkCtl(1, 1, dv, 0, 1, 1, dB, 0));
          for (int t = 0; t < 40; t++) begin
            chk(reqA, pwmOutA, expOut(t, hi, lo, dv));
            chk("R9", pwmOutB, expOut(t, lo, hi, dB));
            @(negedge clk);
          end
          busWr(2, 32'h0);
          chk("R5", pwmOutA, 0);
          chk("R5", pwmOutB, 0);
        end

    // R4: largest prescale on A, smallest on B
    busWr(0, {16'd2, 16'd1});
    busWr(1, {16'd1, 16'd1});
    busWr(2, mkCtl(1, 1, 127, 0, 1, 1, 0, 0));
    for (int t = 0; t < 800; t++) begin
      chk("R4", pwmOutA, expOut(t, 2, 1, 127));
      chk("R9", pwmOutB, expOut(t, 1, 1, 0));
      @(negedge clk);
    end
    busWr(2, 32'h0);

    // R5: output enable alone does not run; clearing and re-enabling restarts
    busWr(0, {16'd3, 16'd2});
    busWr(2, mkCtl(1, 0, 1, 0, 0, 0, 0, 0));
    for (int t = 0; t < 20; t++) begin
      chk("R5", pwmOutA, 0);
      @(negedge clk);
    end
    busWr(2, mkCtl(1, 1, 1, 0, 0, 0, 0, 0));
    for (int t = 0; t < 23; t++) begin
      chk("R5", pwmOutA, expOut(t, 3, 2, 1));
      @(negedge clk);
    end
    busWr(2, mkCtl(0, 1, 1, 0, 0, 0, 0, 0));
    for (int t = 0; t < 5; t++) begin
      chk("R5", pwmOutA, 0);
      @(negedge clk);
    end
    busWr(2, mkCtl(1, 1, 1, 0, 0, 0, 0, 0));
    for (int t = 0; t < 16; t++) begin
      chk("R5", pwmOutA, expOut(t, 3, 2, 1));
      @(negedge clk);
    end
    busWr(2, 32'h0);

    // R7: mute on A, B keeps running
    busWr(0, {16'd2, 16'd2});
    busWr(1, {16'd1, 16'd2});
    busWr(2, mkCtl(1, 1, 0, 1, 1, 1, 0, 0));
    for (int t = 0; t < 30; t++) begin
      chk("R7", pwmOutA, 0);
      chk("R7", pwmOutB, expOut(t, 1, 2, 0));
      @(negedge clk);
    end
    busWr(2, 32'h0);

    // R8: mid-period write takes effect at 20; write on the reload edge waits to 30
    updTest(13, 20);
    updTest(19, 30);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule